// File: doc/BRIEF.md
# Don't-Care-Aware Segment Dictionary Encoder

This block compresses scan test data that contains many unspecified bits. Each pattern arrives already cut into fixed-width segments, one segment per cycle. A symbol is either specified (0 or 1) or a don't-care. The block keeps a small dictionary of segments on chip. Each incoming segment is compared against every stored entry at once. The first compatible entry, counting from the lowest index, absorbs the segment. Compatible means no position where both sides are specified with different values. Absorbing means the entry's don't-care positions take any value the segment specifies there.

A segment with no compatible entry opens a new entry. If no free slot is left, the segment is dropped and flagged. Every mapped segment produces its dictionary index one cycle later. After the segment marked as last, a done pulse presents the final entry count and the index code width needed for that count. The width is the smallest N of at least 1 for which the count is no larger than 2^N.

A host streams segments, collects the index stream, and at done reads the count and the width. It uses these to pack the indices and the dictionary. Between pattern sets the block is reset.

Top module: `xseg_dict_encoder`

## Requirements
- R1: While and after reset, with no segment offered, `entry_count` is 0, `code_width` is 1, and `idx_valid`, `overflow` and `done` are low.
- R2: A segment accepted at a clock edge has its result visible right after that edge. When the dictionary is empty, a segment opens entry 0, raises `idx_valid` with `idx` 0, and makes `entry_count` 1.
- R3: Symbol encoding: `seg_care[i]`=1 means position i is specified with value `seg_val[i]`; `seg_care[i]`=0 is a don't-care. A segment is mapped to an existing entry only if no position is specified in both with different values. Otherwise it opens the next free entry, whose index equals the previous `entry_count`. `idx` is always below `entry_count`.
- R4: When a segment is mapped to an entry, every don't-care position of that entry takes the segment's specified value there. A later segment that conflicts only with such a filled position no longer maps to that entry.
- R5: When several entries are compatible, the one with the lowest index is chosen.
- R6: When all DEPTH entries are in use and no entry is compatible, `overflow` pulses for one cycle, `idx_valid` stays low and `entry_count` is unchanged. A compatible segment is still mapped while the dictionary is full.
- R7: `done` pulses for exactly the cycle after a segment with `seg_last` high is accepted, whether that segment was mapped or dropped. `entry_count` at that point includes that segment. `done` stays low after other segments.
- R8: `code_width` is 1 for a count up to 2, 2 up to 4, 3 up to 8 and 4 up to 16; in general it is the smallest N ≥ 1 with count ≤ 2^N.
- R9: `entry_count` never exceeds DEPTH and rises by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears the dictionary |
| seg_valid | input | 1 | A segment is offered this cycle |
| seg_last | input | 1 | The offered segment is the last one of the set |
| seg_care | input | SEG_W | Per position: 1 specified, 0 don't-care |
| seg_val | input | SEG_W | Per position: value where specified |
| idx_valid | output | 1 | `idx` carries the index of the previous segment |
| idx | output | clog2(DEPTH) | Dictionary index assigned to the segment |
| overflow | output | 1 | Previous segment was dropped, dictionary full |
| done | output | 1 | Previous segment was the last one |
| entry_count | output | clog2(DEPTH+1) | Number of dictionary entries in use |
| code_width | output | clog2(clog2(DEPTH)+1) | Index code width for the current count |

## Verification
The hardest case to reach from the ports is a merge that changes a later decision. The filled-in don't-care positions of an entry are never output directly. So the stimulus first widens entry 0 with a second segment. It then offers a segment that would match entry 0's original form but conflicts with the filled bit, and checks that the segment lands in entry 1 instead. The overflow case needs all sixteen slots occupied by mutually incompatible segments. So the bench fills them with fully specified distinct values, checking the width at every count boundary on the way. It then offers one more new value, then a value already stored.

// File: rtl/xde_pkg.sv
// Package: shared helpers for the segment dictionary encoder.
// Assumes counts fit in a 32-bit unsigned integer.
package xde_pkg;

    // Smallest N >= 1 such that count <= 2**N.
    function automatic int unsigned xde_code_width(int unsigned count);
        int unsigned w;
        w = 1;
        while ((32'd1 << w) < count && w < 31) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/xde_match_row.sv
// Module: compares one dictionary entry with the offered segment and forms
// the merged entry. Assumes don't-care value bits of the entry are zero.
module xde_match_row #(
    parameter int SEG_W = 5
) (
    input  logic [SEG_W-1:0] ent_care,
    input  logic [SEG_W-1:0] ent_val,
    input  logic             ent_used,
    input  logic [SEG_W-1:0] seg_care,
    input  logic [SEG_W-1:0] seg_val,
    output logic             hit,
    output logic [SEG_W-1:0] mrg_care,
    output logic [SEG_W-1:0] mrg_val
);
    logic [SEG_W-1:0] clash;

    // Positions specified on both sides with differing values.
    always_comb clash = ent_care & seg_care & (ent_val ^ seg_val);

    // Entry in use and free of clashes.
    always_comb hit = ent_used && (clash == '0);

    // Fill the entry's don't-care positions from the segment.
    always_comb begin
        mrg_care = ent_care | seg_care;
        mrg_val  = (ent_care & ent_val) | (~ent_care & seg_care & seg_val);
    end
endmodule

// File: rtl/xde_first_hit.sv
// Module: picks the lowest-index hit among N candidates.
// Assumes IW bits are enough to hold N-1.
module xde_first_hit #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] pick
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) pick = IW'(i);
        end
    end

    // Any candidate present.
    always_comb any = |hits;
endmodule

// File: rtl/xde_width_calc.sv
// Module: derives the index code width from the entry count.
// Assumes CW_W bits can hold the widest code for the dictionary depth.
module xde_width_calc #(
    parameter int CNT_W = 5,
    parameter int CW_W  = 3
) (
    input  logic [CNT_W-1:0] count,
    output logic [CW_W-1:0]  width
);
    // Smallest width of at least one bit that covers the count.
    always_comb width = CW_W'(xde_pkg::xde_code_width(32'(count)));
endmodule

// File: rtl/xseg_dict_encoder.sv
// Module: dictionary encoder for ternary segments. Each accepted segment is
// mapped to the first compatible entry (which is merged with it) or to a new
// entry; results are registered one cycle after acceptance.
// Assumes DEPTH >= 2 and one segment per cycle at most.
module xseg_dict_encoder #(
    parameter int SEG_W = 5,
    parameter int DEPTH = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   seg_valid,
    input  logic                                   seg_last,
    input  logic [SEG_W-1:0]                       seg_care,
    input  logic [SEG_W-1:0]                       seg_val,
    output logic                                   idx_valid,
    output logic [$clog2(DEPTH)-1:0]               idx,
    output logic                                   overflow,
    output logic                                   done,
    output logic [$clog2(DEPTH+1)-1:0]             entry_count,
    output logic [$clog2($clog2(DEPTH)+1)-1:0]     code_width
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CW_W  = $clog2(IDX_W + 1);

    logic [SEG_W-1:0] dict_care [DEPTH];
    logic [SEG_W-1:0] dict_val  [DEPTH];
    logic [SEG_W-1:0] mrg_care  [DEPTH];
    logic [SEG_W-1:0] mrg_val   [DEPTH];
    logic [DEPTH-1:0] hits;
    logic [CNT_W-1:0] cnt_q;
    logic             any_hit;
    logic [IDX_W-1:0] pick;
    logic             full;

    // One comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic used;
        always_comb used = (CNT_W'(g) < cnt_q);
        xde_match_row #(.SEG_W(SEG_W)) u_row (
            .ent_care (dict_care[g]),
            .ent_val  (dict_val[g]),
            .ent_used (used),
            .seg_care (seg_care),
            .seg_val  (seg_val),
            .hit      (hits[g]),
            .mrg_care (mrg_care[g]),
            .mrg_val  (mrg_val[g])
        );
    end

    xde_first_hit #(.N(DEPTH), .IW(IDX_W)) u_pick (
        .hits (hits),
        .any  (any_hit),
        .pick (pick)
    );

    xde_width_calc #(.CNT_W(CNT_W), .CW_W(CW_W)) u_width (
        .count (cnt_q),
        .width (code_width)
    );

    // Dictionary has no free slot.
    always_comb full = (cnt_q == CNT_W'(DEPTH));

    // Map, merge, append or drop the offered segment; register the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_valid <= 1'b0;
            idx       <= '0;
            overflow  <= 1'b0;
            done      <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                dict_care[i] <= '0;
                dict_val[i]  <= '0;
            end
        end else begin
            idx_valid <= 1'b0;
            overflow  <= 1'b0;
            done      <= 1'b0;
            if (seg_valid) begin
                done <= seg_last;
                if (any_hit) begin
                    dict_care[pick] <= mrg_care[pick];
                    dict_val[pick]  <= mrg_val[pick];
                    idx_valid       <= 1'b1;
                    idx             <= pick;
                end else if (!full) begin
                    dict_care[IDX_W'(cnt_q)] <= seg_care;
                    dict_val[IDX_W'(cnt_q)]  <= seg_val & seg_care;
                    idx_valid                <= 1'b1;
                    idx                      <= IDX_W'(cnt_q);
                    cnt_q                    <= cnt_q + 1'b1;
                end else begin
                    overflow <= 1'b1;
                end
            end
        end
    end

    // Entry count is presented continuously.
    always_comb entry_count = cnt_q;
endmodule

// File: rtl/xde_checker.sv
// Module: temporal checks on the encoder ports, bound into every instance.
// Assumes the same parameter values as the bound encoder.
module xde_checker #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5,
    parameter int CW_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seg_valid,
    input logic             seg_last,
    input logic             idx_valid,
    input logic [IDX_W-1:0] idx,
    input logic             overflow,
    input logic             done,
    input logic [CNT_W-1:0] entry_count,
    input logic [CW_W-1:0]  code_width
);
    // R2: an index appears only after an offered segment.
    p_idx_after_seg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |-> $past(seg_valid));

    // R3: every index names an entry in use.
    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |-> (32'(idx) < 32'(entry_count)));

    // R6: a dropped segment yields no index and leaves the count alone.
    p_no_overflow_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (!idx_valid && $stable(entry_count)));

    // R6: overflow only after an offered segment at full depth.
    p_overflow_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(seg_valid) && 32'(entry_count) == DEPTH));

    // R7: done only after a segment marked last.
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(seg_valid && seg_last));

    // R8: width is the tightest power-of-two cover of the count.
    p_width_tight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_width >= 1) &&
        (32'(entry_count) <= (32'd1 << code_width)) &&
        (code_width == 1 || 32'(entry_count) > (32'd1 << (code_width - 1))));

    // R9: count bounded by depth and grows by at most one per cycle.
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(entry_count) <= DEPTH) &&
        (entry_count == $past(entry_count) || entry_count == $past(entry_count) + 1'b1));
endmodule

bind xseg_dict_encoder xde_checker #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W),
    .CW_W  (CW_W)
) u_xde_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_valid   (seg_valid),
    .seg_last    (seg_last),
    .idx_valid   (idx_valid),
    .idx         (idx),
    .overflow    (overflow),
    .done        (done),
    .entry_count (entry_count),
    .code_width  (code_width)
);

// File: tb/tb_xseg_dict_encoder.sv
// Directed bench for the segment dictionary encoder; one task per scenario.
module tb_xseg_dict_encoder;
    localparam int SEG_W = 5;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seg_valid = 1'b0;
    logic       seg_last = 1'b0;
    logic [4:0] seg_care = '0;
    logic [4:0] seg_val = '0;
    logic       idx_valid;
    logic [3:0] idx;
    logic       overflow;
    logic       done;
    logic [4:0] entry_count;
    logic [2:0] code_width;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xseg_dict_encoder #(.SEG_W(SEG_W), .DEPTH(DEPTH)) dut (
        .clk (clk), .rst_n (rst_n), .seg_valid (seg_valid), .seg_last (seg_last),
        .seg_care (seg_care), .seg_val (seg_val), .idx_valid (idx_valid),
        .idx (idx), .overflow (overflow), .done (done),
        .entry_count (entry_count), .code_width (code_width)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_width(input int n);
        int w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; seg_valid = 1'b0; seg_last = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one segment, sample just after the accepting edge, then go idle.
    task automatic send(input logic [4:0] c, input logic [4:0] v, input bit last);
        @(negedge clk);
        seg_valid = 1'b1; seg_care = c; seg_val = v; seg_last = last;
        @(posedge clk);
        #1;
        @(negedge clk);
        seg_valid = 1'b0; seg_last = 1'b0;
    endtask

    task automatic expect_idx(input int e, input string req);
        chk(idx_valid === 1'b1, req, int'(idx_valid), 1);
        chk(int'(idx) == e, req, int'(idx), e);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(entry_count == 0, "R1 count", int'(entry_count), 0);
        chk(code_width == 1, "R1 width", int'(code_width), 1);
        chk(!idx_valid && !overflow && !done, "R1 strobes",
            int'({idx_valid, overflow, done}), 0);
    endtask

    task automatic t_merge();
        do_reset();
        send(5'b10100, 5'b10000, 1'b0);             // 1X0XX
        expect_idx(0, "R2 first");
        chk(entry_count == 1, "R2 count", int'(entry_count), 1);
        chk(done == 0, "R7 no done", int'(done), 0);
        send(5'b00101, 5'b00001, 1'b0);             // XX0X1 compatible
        expect_idx(0, "R3 compatible");
        chk(entry_count == 1, "R3 count", int'(entry_count), 1);
        send(5'b10000, 5'b00000, 1'b0);             // 0XXXX clashes
        expect_idx(1, "R3 new entry");
        chk(entry_count == 2, "R3 count2", int'(entry_count), 2);
        send(5'b00001, 5'b00000, 1'b0);             // XXXX0: clashes only with filled bit
        expect_idx(1, "R4 merged bit");
        send(5'b00000, 5'b00000, 1'b1);             // XXXXX matches both
        expect_idx(0, "R5 lowest");
        chk(done == 1, "R7 done", int'(done), 1);
        chk(entry_count == 2, "R7 count", int'(entry_count), 2);
        chk(code_width == 1, "R8 width2", int'(code_width), 1);
        @(posedge clk); #1;
        chk(done == 0, "R7 one cycle", int'(done), 0);
    endtask

    task automatic t_fill();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            send(5'b11111, 5'(i), 1'b0);
            expect_idx(i, "R3 fill");
            chk(int'(code_width) == exp_width(i + 1), "R8 width",
                int'(code_width), exp_width(i + 1));
        end
        chk(entry_count == 16, "R9 full", int'(entry_count), 16);
        send(5'b11111, 5'd17, 1'b0);
        chk(overflow == 1, "R6 overflow", int'(overflow), 1);
        chk(idx_valid == 0, "R6 no idx", int'(idx_valid), 0);
        chk(entry_count == 16, "R6 count", int'(entry_count), 16);
        send(5'b11111, 5'd3, 1'b0);
        expect_idx(3, "R6 map when full");
        chk(overflow == 0, "R6 no ovf", int'(overflow), 0);
        send(5'b11111, 5'd30, 1'b1);
        chk(overflow == 1 && done == 1, "R7 done on drop",
            int'({overflow, done}), 3);
        chk(code_width == 4, "R8 width16", int'(code_width), 4);
    endtask

    initial begin
        t_reset();
        t_merge();
        t_fill();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule